// File: doc/BRIEF.md
# Periodic Down-Count Tick Timer

This block gives a processor a steady interrupt by counting a 24-bit value down to zero over and over. Software reaches it through a simple 32-bit register port. A transfer is active while `bus_sel` is high. Read data and the error flag are combinational in the cycle of the access, and every side effect takes place at the next rising clock edge. Two tick-enable inputs drive the counter: one comes from a slow reference clock and one from the core clock. A bit in the control register chooses which of them decrements the counter.

When the count steps from one to zero, the block records a sticky event flag. If interrupts are enabled, it also raises `irq` for exactly one cycle. On the next selected tick, a counter that sits at zero loads the reload value. A reload value of zero makes the timer stop after it expires, and the enable bit stays set. Only a fresh 0-to-1 write of the enable bit starts it again. Unprivileged accesses are refused with an error and change nothing.

Top module: `tick_timer`

## Requirements
- R1: After reset the control bits, the event flag, the reload value and the counter are all zero, and `irq` is low.
- R2: Word offsets are 0x0 control, 0x4 reload, 0x8 counter and 0xC calibration. In the control word, bit 0 enables counting, bit 1 enables the interrupt, bit 2 selects the tick source and bit 16 is the event flag. All other bits read as zero, and a control write changes only bits 2..0.
- R3: Offset 0xC reads as 10000 decimal. Any other offset reads as zero, and writes to it are ignored.
- R4: A reload write keeps only data bits 23..0.
- R5: While enabled, each selected tick decrements a nonzero counter. A tick on a counter at zero loads the reload value and is not an expiry. Expiry is the step from 1 to 0.
- R6: Expiry sets the event flag. A control read returns the flag and then clears it. If an expiry and a control read fall in the same cycle, the flag ends up set.
- R7: An expiry while bit 1 is set drives `irq` high for exactly the one cycle after the expiring edge. An expiry while bit 1 is clear produces no pulse.
- R8: A write of any data to offset 0x8 sets the counter to zero and clears the event flag. This write takes priority over a tick in the same cycle, and that tick causes no expiry.
- R9: An expiry with reload zero stops counting, and so does a counter write while reload is zero. The enable bit stays set. While stopped, the counter holds at zero even if a new reload value is written.
- R10: With bit 2 at 0, `ref_tick` decrements the counter; with bit 2 at 1, `core_tick` does. Changing bit 2 while running does not reload the counter.
- R11: An access with `bus_priv` low raises `bus_err`, returns zero, and changes no state. In particular, it does not clear the event flag.
- R12: While the enable bit is 0, ticks are ignored. A control write that moves the enable bit from 0 to 1 clears any stop and resumes from the current counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access active this cycle |
| bus_addr | input | 8 | Byte offset of the access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | 1 = privileged access |
| bus_rdata | output | 32 | Read data, valid during a privileged read |
| bus_err | output | 1 | Error response for an unprivileged access |
| ref_tick | input | 1 | Tick enable from the reference clock |
| core_tick | input | 1 | Tick enable from the core clock |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The assertions assume that `bus_addr`, `bus_we` and `bus_wdata` are meaningful only while `bus_sel` is high. They also assume that the tick inputs are single-cycle enables sampled at the rising edge and that at most one access happens per cycle. The stimulus changes every input at the falling edge, one access at a time. Reload values are mostly kept small so that expiries, reloads from zero and the stop-on-zero-reload case occur often. Unprivileged and unmapped accesses are mixed in so that the refusal and ignore paths meet live counter activity.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int FLAG_BIT = 16;

    localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_RELOAD  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CURRENT = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CALIB   = 8'h0C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_RELOAD,
        SEL_CURRENT,
        SEL_CALIB
    } reg_sel_e;

    // bit 2 = tick source, bit 1 = interrupt enable, bit 0 = run
    typedef struct packed {
        logic src_core;
        logic irq_en;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic ctrl;
        logic reload;
        logic current;
    } wr_strb_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_CTRL:    s = SEL_CTRL;
            OFS_RELOAD:  s = SEL_RELOAD;
            OFS_CURRENT: s = SEL_CURRENT;
            OFS_CALIB:   s = SEL_CALIB;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c, input logic flag);
        logic [DATA_W-1:0] r;
        r           = '0;
        r[2:0]      = c;
        r[FLAG_BIT] = flag;
        return r;
    endfunction

endpackage

// File: rtl/tt_bus_decode.sv
module tt_bus_decode
    import tick_timer_pkg::*;
#(
    parameter int               CNT_W     = 24,
    parameter logic [DATA_W-1:0] CAL_VALUE = 32'd10000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sel_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                we_i,
    input  logic                priv_i,
    input  ctrl_t               ctrl_i,
    input  logic                flag_i,
    input  logic [CNT_W-1:0]    reload_i,
    input  logic [CNT_W-1:0]    count_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic                err_o,
    output wr_strb_t            wr_o,
    output logic                rd_ctrl_o
);

    localparam int PAD_W = DATA_W - CNT_W;

    logic     acc_ok;
    reg_sel_e rsel;

    assign acc_ok = sel_i && priv_i;
    assign err_o  = sel_i && !priv_i;
    assign rsel   = decode_addr(addr_i);

    always_comb begin
        wr_o         = '0;
        rd_ctrl_o    = 1'b0;
        rdata_o      = '0;
        if (acc_ok && we_i) begin
            wr_o.ctrl    = (rsel == SEL_CTRL);
            wr_o.reload  = (rsel == SEL_RELOAD);
            wr_o.current = (rsel == SEL_CURRENT);
        end
        if (acc_ok && !we_i) begin
            rd_ctrl_o = (rsel == SEL_CTRL);
            case (rsel)
                SEL_CTRL:    rdata_o = pack_ctrl(ctrl_i, flag_i);
                SEL_RELOAD:  rdata_o = {{PAD_W{1'b0}}, reload_i};
                SEL_CURRENT: rdata_o = {{PAD_W{1'b0}}, count_i};
                SEL_CALIB:   rdata_o = CAL_VALUE;
                default:     rdata_o = '0;
            endcase
        end
    end

    // R11: a refused access neither strobes a register nor returns data
    assert_unpriv_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (wr_o == '0) && !rd_ctrl_o && (rdata_o == '0));

endmodule

// File: rtl/tt_tick_select.sv
module tt_tick_select (
    input  logic src_core_i,
    input  logic ref_tick_i,
    input  logic core_tick_i,
    output logic tick_o
);

    assign tick_o = src_core_i ? core_tick_i : ref_tick_i;

endmodule

// File: rtl/tt_down_counter.sv
module tt_down_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             en_rise_i,
    input  logic             wr_reload_i,
    input  logic             wr_current_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] reload_o,
    output logic             expire_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, cnt_d, reload_q, reload_d;
    logic             stop_q, stop_d;

    always_comb begin
        cnt_d    = cnt_q;
        stop_d   = stop_q;
        reload_d = wr_reload_i ? wdata_i : reload_q;
        expire_o = 1'b0;
        if (tick_i && run_i && !stop_q) begin
            if (cnt_q == '0) begin
                cnt_d = reload_q;
            end else begin
                cnt_d    = cnt_q - ONE;
                expire_o = (cnt_q == ONE);
            end
        end
        if (expire_o && reload_q == '0) stop_d = 1'b1;
        if (wr_current_i) begin
            cnt_d    = '0;
            expire_o = 1'b0;
            if (reload_q == '0) stop_d = 1'b1;
        end
        if (en_rise_i) stop_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            reload_q <= '0;
            stop_q   <= 1'b0;
        end else begin
            cnt_q    <= cnt_d;
            reload_q <= reload_d;
            stop_q   <= stop_d;
        end
    end

    assign count_o  = cnt_q;
    assign reload_o = reload_q;

    // R9: a stopped counter always rests at zero
    assert_stop_at_zero_R9: assert property (@(posedge clk) disable iff (rst)
        stop_q |-> (cnt_q == '0));

    // R8: a counter write leaves zero behind
    assert_cur_write_zero_R8: assert property (@(posedge clk) disable iff (rst)
        wr_current_i |=> (cnt_q == '0));

    // R5: expiry lands the counter on zero
    assert_expire_to_zero_R5: assert property (@(posedge clk) disable iff (rst)
        expire_o |=> (cnt_q == '0));

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int               CNT_W     = 24,
    parameter logic [DATA_W-1:0] CAL_VALUE = 32'd10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_priv,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    input  logic              ref_tick,
    input  logic              core_tick,
    output logic              irq
);

    ctrl_t            ctrl_q, ctrl_d;
    logic             flag_q, flag_d;
    logic             irq_q;
    wr_strb_t         wr;
    logic             rd_ctrl;
    logic             tick_sel;
    logic             en_rise;
    logic             expire;
    logic [CNT_W-1:0] count, reload;

    tt_bus_decode #(.CNT_W(CNT_W), .CAL_VALUE(CAL_VALUE)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .sel_i     (bus_sel),
        .addr_i    (bus_addr),
        .we_i      (bus_we),
        .priv_i    (bus_priv),
        .ctrl_i    (ctrl_q),
        .flag_i    (flag_q),
        .reload_i  (reload),
        .count_i   (count),
        .rdata_o   (bus_rdata),
        .err_o     (bus_err),
        .wr_o      (wr),
        .rd_ctrl_o (rd_ctrl)
    );

    tt_tick_select u_sel (
        .src_core_i  (ctrl_q.src_core),
        .ref_tick_i  (ref_tick),
        .core_tick_i (core_tick),
        .tick_o      (tick_sel)
    );

    assign en_rise = wr.ctrl && bus_wdata[0] && !ctrl_q.run;

    tt_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick_sel),
        .run_i        (ctrl_q.run),
        .en_rise_i    (en_rise),
        .wr_reload_i  (wr.reload),
        .wr_current_i (wr.current),
        .wdata_i      (bus_wdata[CNT_W-1:0]),
        .count_o      (count),
        .reload_o     (reload),
        .expire_o     (expire)
    );

    always_comb begin
        ctrl_d = wr.ctrl ? ctrl_t'(bus_wdata[2:0]) : ctrl_q;
        flag_d = flag_q;
        if (rd_ctrl || wr.current) flag_d = 1'b0;
        if (expire)                flag_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
            flag_q <= flag_d;
            irq_q  <= expire && ctrl_q.irq_en;
        end
    end

    assign irq = irq_q;

    // R6: an expiry always leaves the flag set
    assert_flag_on_expire_R6: assert property (@(posedge clk) disable iff (rst)
        expire |=> flag_q);

    // R7: pulses never run back to back
    assert_irq_single_R7: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R7: a pulse always comes with the flag recorded
    assert_irq_has_flag_R7: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag_q);

    // R11: a refused access leaves control and reload untouched
    assert_unpriv_no_state_R11: assert property (@(posedge clk) disable iff (rst)
        bus_err |=> $stable(ctrl_q) && $stable(reload));

endmodule

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_priv = 1'b1;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        ref_tick = 1'b0;
    logic        core_tick = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    tick_timer u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_priv(bus_priv),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .ref_tick(ref_tick),
        .core_tick(core_tick), .irq(irq)
    );

    // reference model state
    logic        m_en, m_ie, m_src, m_flag, m_stop, m_irq;
    logic [23:0] m_rel, m_cnt;

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h00:   return {15'd0, m_flag, 13'd0, m_src, m_ie, m_en};
            8'h04:   return {8'd0, m_rel};
            8'h08:   return {8'd0, m_cnt};
            8'h0C:   return 32'd10000;
            default: return 32'd0;
        endcase
    endfunction

    task automatic m_reset();
        m_en = 0; m_ie = 0; m_src = 0; m_flag = 0; m_stop = 0; m_irq = 0;
        m_rel = '0; m_cnt = '0;
    endtask

    task automatic m_step(input logic s, w, input logic [7:0] a,
                          input logic [31:0] d, input logic p, rt, ct);
        logic ok, tick, exp_;
        logic [23:0] ncnt;
        ok   = s && p;
        tick = m_en && !m_stop && (m_src ? ct : rt);
        exp_ = 0;
        ncnt = m_cnt;
        if (tick) begin
            if (m_cnt == 0) ncnt = m_rel;
            else begin ncnt = m_cnt - 1; exp_ = (m_cnt == 1); end
        end
        m_irq = exp_ && m_ie;
        if (exp_ && m_rel == 0) m_stop = 1;
        if (ok && !w && a == 8'h00) m_flag = 0;
        if (ok && w && a == 8'h08) begin
            ncnt = 0; m_irq = 0; exp_ = 0; m_flag = 0;
            if (m_rel == 0) m_stop = 1;
        end
        if (exp_) m_flag = 1;
        if (ok && w && a == 8'h04) m_rel = d[23:0];
        if (ok && w && a == 8'h00) begin
            if (d[0] && !m_en) m_stop = 0;
            {m_src, m_ie, m_en} = d[2:0];
        end
        m_cnt = ncnt;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
        end
    endtask

    task automatic step(input logic s, w, input logic [7:0] a, input logic [31:0] d,
                        input logic p, rt, ct, input string tag);
        @(negedge clk);
        bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d; bus_priv = p;
        ref_tick = rt; core_tick = ct;
        #1;
        chk(tag, bus_rdata, (s && p && !w) ? m_read(a) : 32'd0);
        chk("R11 err", {31'd0, bus_err}, {31'd0, s && !p});
        chk("R7 irq", {31'd0, irq}, {31'd0, m_irq});
        m_step(s, w, a, d, p, rt, ct);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        step(1, 1, a, d, 1, 0, 0, tag);
    endtask
    task automatic rd(input logic [7:0] a, input string tag);
        step(1, 0, a, 0, 1, 0, 0, tag);
    endtask
    task automatic tk(input logic rt, ct, input string tag);
        step(0, 0, 0, 0, 1, rt, ct, tag);
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_dummy;
        m_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(8'h00, "R1 ctrl"); rd(8'h04, "R1 reload"); rd(8'h08, "R1 count");
        // R3 calibration and unmapped offsets
        rd(8'h0C, "R3 calib"); rd(8'h10, "R3 unmapped");
        wr(8'h10, 32'hFFFF_FFFF, "R3 wr"); rd(8'h04, "R3 reload"); rd(8'h00, "R3 ctrl");
        // R4 reload mask
        wr(8'h04, 32'hFFFF_FFFF, "R4 wr"); rd(8'h04, "R4 mask");
        // R2 control write keeps only bits 2..0
        wr(8'h00, 32'hFFFF_FFF8, "R2 wr"); rd(8'h00, "R2 ctrl");
        // R8 counter write clears; R5 count sequence
        wr(8'h04, 32'd3, "R4 wr3");
        wr(8'h08, 32'h55, "R8 wr"); rd(8'h08, "R8 zero");
        wr(8'h00, 32'h3, "R2 en");
        for (int i = 0; i < 4; i++) begin tk(1, 0, "R5 tick"); rd(8'h08, "R5 count"); end
        rd(8'h00, "R6 flag"); rd(8'h00, "R6 clear");
        // R10 source select
        tk(0, 1, "R10 core ignored"); rd(8'h08, "R10 count");
        tk(1, 0, "R10 ref"); rd(8'h08, "R10 count");
        wr(8'h00, 32'h7, "R10 switch"); rd(8'h08, "R10 no reload");
        tk(1, 0, "R10 ref ignored"); tk(0, 1, "R10 core"); rd(8'h08, "R10 core count");
        // R12 disable holds, re-enable resumes
        wr(8'h00, 32'h6, "R12 off"); tk(0, 1, "R12 t"); tk(0, 1, "R12 t");
        rd(8'h08, "R12 held");
        wr(8'h00, 32'h7, "R12 on"); tk(0, 1, "R12 t"); rd(8'h08, "R12 resumed");
        // R9 reload zero stops after expiry
        wr(8'h04, 32'd0, "R9 rel0");
        for (int i = 0; i < 5; i++) tk(0, 1, "R9 t");
        rd(8'h00, "R9 enable kept"); rd(8'h08, "R9 zero");
        wr(8'h04, 32'd5, "R9 rel5"); tk(0, 1, "R9 t"); tk(0, 1, "R9 t");
        rd(8'h08, "R9 still stopped");
        wr(8'h00, 32'h6, "R12 off"); wr(8'h00, 32'h7, "R12 on");
        tk(0, 1, "R12 t"); rd(8'h08, "R12 restart");
        // R11 unprivileged write and read
        for (int i = 0; i < 6; i++) tk(0, 1, "R11 t");
        step(1, 1, 8'h00, 32'h0, 0, 0, 0, "R11 wr");
        step(1, 0, 8'h00, 32'h0, 0, 0, 0, "R11 rd");
        rd(8'h00, "R11 flag kept"); rd(8'h04, "R11 reload");
        // R6 set wins over read-clear: bring count to 1, then read+tick
        wr(8'h04, 32'd2, "R6 rel"); wr(8'h08, 32'd0, "R8 wr");
        tk(0, 1, "R6 t"); tk(0, 1, "R6 t");
        step(1, 0, 8'h00, 0, 1, 0, 1, "R6 rd+tick"); rd(8'h00, "R6 set wins");
        // R8 counter write beats tick at 1
        tk(0, 1, "R8 t"); tk(0, 1, "R8 t");
        step(1, 1, 8'h08, 32'hABC, 1, 0, 1, "R8 wr+tick"); rd(8'h00, "R8 no flag");
        tk(0, 0, "R8 no irq");
        // random phase
        seed_dummy = $urandom(32'd20240611);
        for (int i = 0; i < 6000; i++) begin
            logic s, w, p;
            logic [7:0] a;
            logic [31:0] d;
            int k;
            s = ($urandom % 4) == 0;
            w = $urandom % 2;
            p = ($urandom % 8) != 0;
            k = $urandom % 6;
            a = (k == 5) ? 8'($urandom) : 8'(k * 4);
            if (a == 8'h00 && w) d = {$urandom, 1'b0} | 32'((($urandom % 6) != 0));
            else d = (($urandom % 4) == 0) ? $urandom : 32'($urandom % 6);
            step(s, w, a, d, p, ($urandom % 2) == 1, ($urandom % 3) == 0,
                 (a == 8'h00) ? "R6 rnd" : (a == 8'h08) ? "R5 rnd" : "R3 rnd");
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule